// File: doc/BRIEF.md
# Host-to-CAN-Controller Interrupt Gating Glue

This block sits between a host I/O request bus and an add-on CAN controller. Each host request picks one of three address windows through a one-hot select. The windows are a 128-byte bridge register window, a 128-byte controller pass-through window and an 8-byte board-logic window. The bridge window holds one 32-bit interrupt control/status word. Bit 13 of that word decides whether the controller's level interrupt reaches the host interrupt pin. Bit 23 always reads back the live interrupt level.

Requests to the controller window at offsets below 0x20 become a one-cycle strobe on a byte-wide slave port. Requests at higher offsets are dropped. The board-logic window answers with a fixed version byte at offset 7.

The host side uses valid/ready. The host raises `req_valid` with its address, data and controls, and holds them steady until `req_ready` pulses for one cycle. It then drops `req_valid` before it issues the next request. The block applies back-pressure only by holding `req_ready` low until the request has completed. `rsp_rdata` is valid in the cycle in which `req_ready` is high.

Top module: `canbr_glue`

## Requirements
- R1: During reset and directly after it, `host_irq`, `req_ready` and `ctl_stb` are low, and the interrupt control word reads as zero.
- R2: A 4-byte write (`req_wide`=1) to bridge offset 0x38 stores the whole 32-bit word. A later 4-byte read at 0x38 returns that word, except for bit 23.
- R3: Bit 23 of a read at bridge offset 0x38 equals the `addon_irq` level sampled at the previous clock edge, whatever value was written to that bit.
- R4: `host_irq` equals the sampled `addon_irq` level ANDed with stored bit 13. It follows an enable write in the same cycle as that write's `req_ready`, and it follows a change of the interrupt level one edge later.
- R5: In the bridge window, byte accesses (`req_wide`=0) and every offset other than 0x38 are ignored. Reads of them return zero and writes to them change nothing.
- R6: A controller-window access at an offset below 0x20 produces exactly one `ctl_stb` pulse, one cycle after acceptance. The pulse carries `ctl_addr` = offset[4:0], `ctl_we`, and `ctl_wdata` = `req_wdata`[7:0]. A read returns the `ctl_rdata` byte from the cycle after the strobe, in bits 7:0.
- R7: A controller-window access at an offset of 0x20 or above produces no strobe and reads back zero.
- R8: In the board-logic window, a read of offset 7 returns 0xD0 (version 13 in bits 7:4, zero in bits 3:0). Other offsets read zero, and writes have no effect.
- R9: Each request gets exactly one single-cycle `req_ready` pulse. It comes 1 cycle after acceptance for bridge, board and dropped accesses, and 3 cycles after acceptance for forwarded controller accesses.
- R10: A request whose `req_win` is not one-hot is acknowledged after 1 cycle with zero data. It causes no strobe and no register change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Host request valid; held until req_ready |
| req_win | input | 3 | One-hot window select: bit0 bridge, bit1 controller, bit2 board |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wide | input | 1 | 1 = 4-byte access, 0 = byte access |
| req_addr | input | 7 | Byte offset inside the selected window |
| req_wdata | input | 32 | Write data |
| req_ready | output | 1 | Single-cycle completion pulse |
| rsp_rdata | output | 32 | Read data, valid with req_ready |
| ctl_stb | output | 1 | One-cycle strobe to controller port |
| ctl_we | output | 1 | Controller port write flag |
| ctl_addr | output | 5 | Controller register offset |
| ctl_wdata | output | 8 | Controller write byte |
| ctl_rdata | input | 8 | Controller read byte, valid the cycle after ctl_stb |
| addon_irq | input | 1 | Level interrupt from the controller |
| host_irq | output | 1 | Gated host interrupt |

## Verification
A request that the bench drives on a falling edge is accepted at the next rising edge. Local windows then answer with `req_ready` at the following falling edge. Forwarded controller accesses raise the strobe one sample after acceptance and answer three samples after acceptance. The bench counts the falling edges until `req_ready` and checks that count against 1 or 3. A scoreboard monitor compares each response as `req_ready` is seen. `host_irq` is sampled at the falling edge that carries the enable write's ready, or one falling edge after an `addon_irq` change, which matches the single capture register in that path.

// File: rtl/canbr_pkg.sv
package canbr_pkg;
  localparam int WIN_CNT = 3;
  localparam int WIN_BRG = 0;
  localparam int WIN_CTL = 1;
  localparam int WIN_BRD = 2;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_STB,
    ST_WAIT,
    ST_ACK
  } seq_e;
endpackage

// File: rtl/canbr_icr.sv
module canbr_icr #(
  parameter int DATA_W   = 32,
  parameter int EN_BIT   = 13,
  parameter int STAT_BIT = 23
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_word,
  input  logic              addon_irq,
  output logic [DATA_W-1:0] rd_word,
  output logic              host_irq
);
  logic [DATA_W-1:0] icr_q;
  logic              pend_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      icr_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      pend_q <= addon_irq;
      if (wr_en) icr_q <= wr_word;
    end
  end

  // status bit shows the live pending level, never the stored copy
  always_comb begin
    rd_word           = icr_q;
    rd_word[STAT_BIT] = pend_q;
  end

  // any enable flip while pending re-drives the line at once
  assign host_irq = pend_q & icr_q[EN_BIT];
endmodule

// File: rtl/canbr_board.sv
module canbr_board #(
  parameter int ADDR_W  = 7,
  parameter int VER_OFS = 7,
  parameter int VERSION = 13
) (
  input  logic [ADDR_W-1:0] addr,
  output logic [7:0]        rd_byte
);
  localparam logic [ADDR_W-1:0] VER_ADDR = ADDR_W'(VER_OFS);
  localparam logic [7:0]        VER_BYTE = {4'(VERSION), 4'h0};

  assign rd_byte = (addr == VER_ADDR) ? VER_BYTE : 8'h00;
endmodule

// File: rtl/canbr_glue.sv
module canbr_glue
  import canbr_pkg::*;
#(
  parameter int ADDR_W   = 7,
  parameter int DATA_W   = 32,
  parameter int CTL_SPAN = 32,
  parameter int ICR_OFS  = 'h38,
  parameter int EN_BIT   = 13,
  parameter int STAT_BIT = 23,
  parameter int VER_OFS  = 7,
  parameter int VERSION  = 13,
  localparam int CTL_AW  = $clog2(CTL_SPAN)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [WIN_CNT-1:0] req_win,
  input  logic               req_we,
  input  logic               req_wide,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [DATA_W-1:0]  req_wdata,
  output logic               req_ready,
  output logic [DATA_W-1:0]  rsp_rdata,
  output logic               ctl_stb,
  output logic               ctl_we,
  output logic [CTL_AW-1:0]  ctl_addr,
  output logic [7:0]         ctl_wdata,
  input  logic [7:0]         ctl_rdata,
  input  logic               addon_irq,
  output logic               host_irq
);
  localparam logic [ADDR_W-1:0] ICR_ADDR = ADDR_W'(ICR_OFS);
  localparam logic [ADDR_W-1:0] CTL_LIM  = ADDR_W'(CTL_SPAN);

  seq_e              state_q;
  logic              win_ok, sel_brg, sel_ctl, sel_brd;
  logic              brg_hit, ctl_hit, accept, icr_wr;
  logic              ctl_rd_q;
  logic [DATA_W-1:0] icr_word, local_rd;
  logic [7:0]        brd_byte;

  // window decode: anything not one-hot selects nothing
  assign win_ok  = (req_win != '0) && ((req_win & (req_win - 1'b1)) == '0);
  assign sel_brg = win_ok & req_win[WIN_BRG];
  assign sel_ctl = win_ok & req_win[WIN_CTL];
  assign sel_brd = win_ok & req_win[WIN_BRD];

  assign brg_hit = sel_brg & req_wide & (req_addr == ICR_ADDR);
  assign ctl_hit = sel_ctl & (req_addr < CTL_LIM);
  assign accept  = req_valid & (state_q == ST_IDLE);
  assign icr_wr  = accept & brg_hit & req_we;

  canbr_icr #(
    .DATA_W  (DATA_W),
    .EN_BIT  (EN_BIT),
    .STAT_BIT(STAT_BIT)
  ) u_icr (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (icr_wr),
    .wr_word  (req_wdata),
    .addon_irq(addon_irq),
    .rd_word  (icr_word),
    .host_irq (host_irq)
  );

  canbr_board #(
    .ADDR_W (ADDR_W),
    .VER_OFS(VER_OFS),
    .VERSION(VERSION)
  ) u_brd (
    .addr   (req_addr),
    .rd_byte(brd_byte)
  );

  always_comb begin
    local_rd = '0;
    if (!req_we) begin
      if (brg_hit)      local_rd = icr_word;
      else if (sel_brd) local_rd = {{(DATA_W-8){1'b0}}, brd_byte};
    end
  end

  // request sequencer: local answers in one cycle, forwarded in three
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      req_ready <= 1'b0;
      rsp_rdata <= '0;
      ctl_stb   <= 1'b0;
      ctl_we    <= 1'b0;
      ctl_addr  <= '0;
      ctl_wdata <= '0;
      ctl_rd_q  <= 1'b0;
    end else begin
      req_ready <= 1'b0;
      ctl_stb   <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            if (ctl_hit) begin
              ctl_stb   <= 1'b1;
              ctl_we    <= req_we;
              ctl_addr  <= req_addr[CTL_AW-1:0];
              ctl_wdata <= req_wdata[7:0];
              ctl_rd_q  <= !req_we;
              state_q   <= ST_STB;
            end else begin
              req_ready <= 1'b1;
              rsp_rdata <= local_rd;
              state_q   <= ST_ACK;
            end
          end
        end
        ST_STB:  state_q <= ST_WAIT;
        ST_WAIT: begin
          req_ready <= 1'b1;
          rsp_rdata <= ctl_rd_q ? {{(DATA_W-8){1'b0}}, ctl_rdata} : '0;
          state_q   <= ST_ACK;
        end
        ST_ACK:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/canbr_chk.sv
module canbr_chk (
  input logic clk,
  input logic rst_n,
  input logic req_ready,
  input logic ctl_stb,
  input logic addon_irq,
  input logic host_irq
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!rst_n) |-> (!host_irq && !req_ready && !ctl_stb));

  // R4
  irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> $past(addon_irq));

  // R9
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |=> !req_ready);

  // R6
  stb_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_stb |=> (!ctl_stb && !req_ready));

  // R9
  stb_no_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ctl_stb |-> !req_ready);
endmodule

bind canbr_glue canbr_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_ready(req_ready),
  .ctl_stb  (ctl_stb),
  .addon_irq(addon_irq),
  .host_irq (host_irq)
);

// File: tb/sim_canbr_glue.sv
`timescale 1ns/1ps
module sim_canbr_glue;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [2:0]  req_win = 3'b000;
  logic        req_we = 1'b0;
  logic        req_wide = 1'b0;
  logic [6:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        req_ready;
  logic [31:0] rsp_rdata;
  logic        ctl_stb, ctl_we;
  logic [4:0]  ctl_addr;
  logic [7:0]  ctl_wdata;
  logic [7:0]  ctl_rdata = 8'h00;
  logic        addon_irq = 1'b0;
  logic        host_irq;

  int checks = 0;
  int fails  = 0;
  int stb_cnt = 0;
  bit done = 0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [7:0]  slave_mem [32];

  always #2 clk = ~clk;

  canbr_glue u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_win(req_win),
    .req_we(req_we), .req_wide(req_wide), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_ready(req_ready), .rsp_rdata(rsp_rdata),
    .ctl_stb(ctl_stb), .ctl_we(ctl_we), .ctl_addr(ctl_addr),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
    .addon_irq(addon_irq), .host_irq(host_irq)
  );

  // controller slave model: read byte appears the cycle after the strobe
  always @(posedge clk) begin
    if (ctl_stb) begin
      stb_cnt <= stb_cnt + 1;
      if (ctl_we) slave_mem[ctl_addr] <= ctl_wdata;
      ctl_rdata <= ctl_we ? 8'h00 : slave_mem[ctl_addr];
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && req_ready) begin
      if (exp_q.size() == 0) begin
        chk(0, "R9", "unexpected ready", 32'h1, 32'h0);
      end else begin
        automatic logic [31:0] e = exp_q.pop_front();
        automatic string t = tag_q.pop_front();
        chk(rsp_rdata === e, t, "response data", rsp_rdata, e);
      end
    end
  end

  task automatic access(input logic [2:0] win, input logic we, input logic wide,
                        input logic [6:0] addr, input logic [31:0] wd,
                        input logic [31:0] exp, input string tag, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_win = win; req_we = we; req_wide = wide;
    req_addr = addr; req_wdata = wd;
    exp_q.push_back(exp);
    tag_q.push_back(tag);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!req_ready && lat < 20);
    req_valid = 1'b0;
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(0, "R9", "watchdog expired", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    int lat;
    int s0;
    for (int i = 0; i < 32; i++) slave_mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset
    chk(!host_irq && !req_ready && !ctl_stb, "R1", "outputs in reset",
        {29'b0, host_irq, req_ready, ctl_stb}, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!host_irq && !req_ready && !ctl_stb, "R1", "outputs after reset",
        {29'b0, host_irq, req_ready, ctl_stb}, 32'h0);
    access(3'b001, 0, 1, 7'h38, 0, 32'h0, "R1", lat);
    chk(lat == 1, "R9", "bridge read latency", lat, 1);

    // R2/R3: stored word, bit 23 replaced by live level (0)
    access(3'b001, 1, 1, 7'h38, 32'hA5A5_0F0F, 32'h0, "R2", lat);
    chk(lat == 1, "R9", "bridge write latency", lat, 1);
    access(3'b001, 0, 1, 7'h38, 0, 32'hA525_0F0F, "R2", lat);

    // R5: byte access and other offsets ignored
    access(3'b001, 1, 0, 7'h38, 32'hFFFF_FFFF, 32'h0, "R5", lat);
    access(3'b001, 0, 0, 7'h38, 0, 32'h0, "R5", lat);
    access(3'b001, 1, 1, 7'h3C, 32'hFFFF_FFFF, 32'h0, "R5", lat);
    access(3'b001, 0, 1, 7'h3C, 0, 32'h0, "R5", lat);
    access(3'b001, 0, 1, 7'h38, 0, 32'hA525_0F0F, "R5", lat);

    // R3: live pending shows in bit 23, no host irq while disabled
    @(negedge clk); addon_irq = 1'b1;
    @(negedge clk);
    chk(host_irq == 1'b0, "R4", "host_irq with enable clear", host_irq, 0);
    access(3'b001, 0, 1, 7'h38, 0, 32'hA5A5_0F0F, "R3", lat);

    // R4: enabling while pending drives host_irq with the write's ready
    access(3'b001, 1, 1, 7'h38, 32'h0000_2000, 32'h0, "R4", lat);
    chk(host_irq == 1'b1, "R4", "host_irq after enable write", host_irq, 1);
    access(3'b001, 0, 1, 7'h38, 0, 32'h0080_2000, "R3", lat);
    addon_irq = 1'b0;
    @(negedge clk);
    chk(host_irq == 1'b0, "R4", "host_irq follows level low", host_irq, 0);
    access(3'b001, 0, 1, 7'h38, 0, 32'h0000_2000, "R3", lat);
    addon_irq = 1'b1;
    @(negedge clk);
    chk(host_irq == 1'b1, "R4", "host_irq follows level high", host_irq, 1);
    access(3'b001, 1, 1, 7'h38, 32'h0000_0000, 32'h0, "R4", lat);
    chk(host_irq == 1'b0, "R4", "host_irq after disable write", host_irq, 0);

    // R6: forwarded controller accesses
    s0 = stb_cnt;
    access(3'b010, 1, 0, 7'h05, 32'hFFFF_FF3C, 32'h0, "R6", lat);
    chk(lat == 3, "R9", "controller write latency", lat, 3);
    chk(stb_cnt == s0 + 1, "R6", "one strobe per write", stb_cnt, s0 + 1);
    chk(slave_mem[5] == 8'h3C, "R6", "slave byte written", {24'b0, slave_mem[5]}, 32'h3C);
    access(3'b010, 0, 0, 7'h05, 0, 32'h0000_003C, "R6", lat);
    chk(lat == 3, "R9", "controller read latency", lat, 3);
    access(3'b010, 1, 0, 7'h1F, 32'h0000_0081, 32'h0, "R6", lat);
    access(3'b010, 0, 0, 7'h1F, 0, 32'h0000_0081, "R6", lat);
    chk(stb_cnt == s0 + 4, "R6", "strobe count", stb_cnt, s0 + 4);

    // R7: at or beyond 0x20 dropped
    s0 = stb_cnt;
    access(3'b010, 1, 0, 7'h25, 32'h0000_0077, 32'h0, "R7", lat);
    chk(lat == 1, "R7", "dropped write latency", lat, 1);
    access(3'b010, 0, 0, 7'h20, 0, 32'h0, "R7", lat);
    chk(stb_cnt == s0, "R7", "no strobe out of range", stb_cnt, s0);
    chk(slave_mem[5] == 8'h3C, "R7", "aliased byte untouched", {24'b0, slave_mem[5]}, 32'h3C);

    // R8: board window
    access(3'b100, 0, 0, 7'h07, 0, 32'h0000_00D0, "R8", lat);
    access(3'b100, 0, 0, 7'h03, 0, 32'h0, "R8", lat);
    access(3'b100, 1, 0, 7'h07, 32'h0000_0011, 32'h0, "R8", lat);
    access(3'b100, 0, 0, 7'h07, 0, 32'h0000_00D0, "R8", lat);

    // R10: bad window select
    s0 = stb_cnt;
    access(3'b011, 0, 1, 7'h38, 0, 32'h0, "R10", lat);
    chk(lat == 1, "R10", "bad select latency", lat, 1);
    access(3'b011, 1, 1, 7'h38, 32'h0000_2000, 32'h0, "R10", lat);
    access(3'b000, 1, 0, 7'h05, 32'h0000_0099, 32'h0, "R10", lat);
    chk(stb_cnt == s0, "R10", "no strobe on bad select", stb_cnt, s0);
    chk(host_irq == 1'b0, "R10", "enable not stored", host_irq, 0);
    access(3'b001, 0, 1, 7'h38, 0, 32'h0080_0000, "R10", lat);

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R9", "all responses seen", exp_q.size(), 0);
    finish_run();
  end
endmodule